// File: doc/BRIEF.md
# Command Mailbox Register With Busy Handshake

This block holds the 16-bit word through which a host processor passes commands to a communications co-processor. The host writes the word over a simple register bus. The block latches an opcode and a channel number from the word and raises a busy flag inside it. The co-processor acts on the latched fields and pulses a done input when it finishes. The done pulse clears the busy flag, which tells the host that the next command may be written. Non-reset writes that arrive while the flag is still up are dropped, and a sticky error flag records each one.

One encoding, 0x8001, is a reset command. It is accepted whatever the busy flag shows and overrides any pending command. It sends a one-cycle reset pulse toward the co-processor, clears the latched opcode and channel, and holds busy until done comes back.

A second, byte-wide debug register sits beside the mailbox. It holds a single enable bit that allows microcode to run from the upper half of the co-processor's shared RAM. When the bit is 0, microcode runs only from the first 2 KB.

The word uses MSB-first numbering. Bit 0 is the most significant bit and sits on data line 15. Bit 15 is the least significant bit and sits on data line 0.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the mailbox word and the debug register read 0x0000, and busy, error, reset pulse and RAM enable are all 0.
- R2: A write to offset 0x9C0, while idle, of a word other than 0x8001 is a command. It latches the opcode from data[11:8] and the channel from data[7:4] and sets busy. The word then reads back with those fields, busy on data[0], and all other lines 0.
- R3: A done pulse while busy clears busy on the next cycle. The opcode and channel stay latched.
- R4: A write to offset 0x9C0 of any word other than 0x8001, made while busy and without done in the same cycle, is ignored. The stored word stays unchanged.
- R5: Every ignored write under R4 sets the error output. The error output stays set until reset.
- R6: If done and a command write arrive in the same cycle, the write is applied. Busy stays set with the new fields, and the error output is not raised.
- R7: Writing 0x8001 to offset 0x9C0 is accepted busy or not. The reset output pulses high for exactly the one cycle after the write. Opcode and channel clear. The word reads 0x8001 until done, and reads 0x0000 afterwards.
- R8: A done pulse while not busy leaves the word unchanged.
- R9: A write to offset 0x9C7 stores data[7] as the RAM-extension enable and drives it on ram_ext_en. The register reads back as 0x0080 or 0x0000, and data[6:0] always read 0.
- R10: Reads from any offset other than 0x9C0 and 0x9C7 return 0. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| done_i | input | 1 | Completion pulse from the co-processor |
| cmd_opcode | output | 4 | Latched opcode |
| cmd_channel | output | 4 | Latched channel number |
| busy | output | 1 | Busy flag (word data[0]) |
| cmd_rst_req | output | 1 | One-cycle reset request pulse |
| err_sticky | output | 1 | Sticky flag for writes dropped while busy |
| ram_ext_en | output | 1 | Microcode RAM-extension enable |

## Verification
A wrong busy flag shows on the busy port one cycle after the write or done edge that should have moved it. It then shows as a command that was wrongly dropped or wrongly taken: a latched opcode that does not change, or an error flag that rises. A mis-decoded reset command shows as a missing or stretched pulse on cmd_rst_req in the cycle after the write, and as opcode bits that are not cleared. A field taken from the wrong data lines shows at once in the read data of the next read.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 4;
    localparam int BYTE_W  = 8;

    // MSB-first bit number to data line index
    function automatic int line_of(input int msb_bit);
        return WORD_W - 1 - msb_bit;
    endfunction

    localparam int RST_LINE  = line_of(0);          // 15
    localparam int OPC_HI    = line_of(4);          // 11
    localparam int OPC_LO    = line_of(7);          // 8
    localparam int CHAN_HI   = line_of(8);          // 7
    localparam int CHAN_LO   = line_of(11);         // 4
    localparam int BUSY_LINE = line_of(15);         // 0
    localparam int EXT_LINE  = BYTE_W - 1;          // byte MSB

    localparam logic [WORD_W-1:0] RST_WORD =
        (WORD_W'(1) << RST_LINE) | (WORD_W'(1) << BUSY_LINE);

    typedef struct packed {
        logic               rst_flag;
        logic [FIELD_W-1:0] opcode;
        logic [FIELD_W-1:0] chan;
        logic               busy;
        logic               err;
        logic               rst_pulse;
    } cmd_state_t;

endpackage

// File: rtl/cmd_mailbox_decode.sv
module cmd_mailbox_decode #(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h9C0,
    parameter logic [ADDR_W-1:0] DBG_OFFSET = 12'h9C7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              hit_cmd,
    output logic              hit_dbg,
    output logic              wr_cmd,
    output logic              wr_dbg
);
    always_comb begin
        hit_cmd = (addr == CMD_OFFSET);
        hit_dbg = (addr == DBG_OFFSET);
        wr_cmd  = we && hit_cmd;
        wr_dbg  = we && hit_dbg;
    end
endmodule

// File: rtl/cmd_mailbox_cmdreg.sv
module cmd_mailbox_cmdreg
    import cmd_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    output logic [WORD_W-1:0] word,
    output logic [FIELD_W-1:0] opcode,
    output logic [FIELD_W-1:0] chan,
    output logic              busy,
    output logic              err,
    output logic              rst_pulse
);
    cmd_state_t st_d, st_q;
    logic       is_rst_cmd;

    always_comb begin
        is_rst_cmd   = (wdata == RST_WORD);
        st_d         = st_q;
        st_d.rst_pulse = 1'b0;

        if (st_q.busy && done) begin
            st_d.busy     = 1'b0;
            st_d.rst_flag = 1'b0;
        end

        if (wr) begin
            if (is_rst_cmd) begin
                st_d.rst_flag  = 1'b1;
                st_d.opcode    = '0;
                st_d.chan      = '0;
                st_d.busy      = 1'b1;
                st_d.rst_pulse = 1'b1;
            end else if (st_q.busy && !done) begin
                st_d.err = 1'b1;
            end else begin
                st_d.rst_flag = 1'b0;
                st_d.opcode   = wdata[OPC_HI:OPC_LO];
                st_d.chan     = wdata[CHAN_HI:CHAN_LO];
                st_d.busy     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word                   = '0;
        word[RST_LINE]         = st_q.rst_flag;
        word[OPC_HI:OPC_LO]    = st_q.opcode;
        word[CHAN_HI:CHAN_LO]  = st_q.chan;
        word[BUSY_LINE]        = st_q.busy;
        opcode                 = st_q.opcode;
        chan                   = st_q.chan;
        busy                   = st_q.busy;
        err                    = st_q.err;
        rst_pulse              = st_q.rst_pulse;
    end
endmodule

// File: rtl/cmd_mailbox_dbgreg.sv
module cmd_mailbox_dbgreg
    import cmd_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [WORD_W-1:0] word,
    output logic              ext_en
);
    logic ext_d, ext_q;

    always_comb begin
        ext_d = ext_q;
        if (wr) ext_d = wbyte[EXT_LINE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
    end

    always_comb begin
        word           = '0;
        word[EXT_LINE] = ext_q;
        ext_en         = ext_q;
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h9C0,
    parameter logic [ADDR_W-1:0] DBG_OFFSET = 12'h9C7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               done_i,
    output logic [FIELD_W-1:0] cmd_opcode,
    output logic [FIELD_W-1:0] cmd_channel,
    output logic               busy,
    output logic               cmd_rst_req,
    output logic               err_sticky,
    output logic               ram_ext_en
);
    logic              hit_cmd, hit_dbg, wr_cmd, wr_dbg;
    logic [WORD_W-1:0] cmd_word, dbg_word;

    cmd_mailbox_decode #(
        .ADDR_W(ADDR_W), .CMD_OFFSET(CMD_OFFSET), .DBG_OFFSET(DBG_OFFSET)
    ) u_decode (
        .addr(bus_addr), .we(bus_we),
        .hit_cmd(hit_cmd), .hit_dbg(hit_dbg),
        .wr_cmd(wr_cmd), .wr_dbg(wr_dbg)
    );

    cmd_mailbox_cmdreg u_cmdreg (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_cmd), .wdata(bus_wdata), .done(done_i),
        .word(cmd_word), .opcode(cmd_opcode), .chan(cmd_channel),
        .busy(busy), .err(err_sticky), .rst_pulse(cmd_rst_req)
    );

    cmd_mailbox_dbgreg u_dbgreg (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_dbg), .wbyte(bus_wdata[BYTE_W-1:0]),
        .word(dbg_word), .ext_en(ram_ext_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_cmd)      bus_rdata = cmd_word;
        else if (hit_dbg) bus_rdata = dbg_word;
    end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
    import cmd_mailbox_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h9C0,
    parameter logic [ADDR_W-1:0] DBG_OFFSET = 12'h9C7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic               bus_we,
    input logic               done_i,
    input logic [FIELD_W-1:0] cmd_opcode,
    input logic [FIELD_W-1:0] cmd_channel,
    input logic               busy,
    input logic               cmd_rst_req,
    input logic               err_sticky,
    input logic               ram_ext_en
);
    logic cmd_wr, dbg_wr;
    assign cmd_wr = bus_we && (bus_addr == CMD_OFFSET);
    assign dbg_wr = bus_we && (bus_addr == DBG_OFFSET);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr));

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done_i));

    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && bus_wdata != RST_WORD && !done_i)
            |=> (busy && $stable(cmd_opcode) && $stable(cmd_channel)));

    // R5
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R7
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_req |=> !cmd_rst_req);

    // R7
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_req |-> (busy && cmd_opcode == '0 && cmd_channel == '0));

    // R9
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_wr |=> $stable(ram_ext_en));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(
    .ADDR_W(ADDR_W), .CMD_OFFSET(CMD_OFFSET), .DBG_OFFSET(DBG_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .done_i(done_i), .cmd_opcode(cmd_opcode),
    .cmd_channel(cmd_channel), .busy(busy), .cmd_rst_req(cmd_rst_req),
    .err_sticky(err_sticky), .ram_ext_en(ram_ext_en)
);

// File: tb/cmd_mailbox_bench.sv
`timescale 1ns/1ps
module cmd_mailbox_bench;
    localparam logic [11:0] A_CMD = 12'h9C0;
    localparam logic [11:0] A_DBG = 12'h9C7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        done_i = 1'b0;
    logic [3:0]  cmd_opcode, cmd_channel;
    logic        busy, cmd_rst_req, err_sticky, ram_ext_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmd_mailbox u_cmd_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .done_i(done_i),
        .cmd_opcode(cmd_opcode), .cmd_channel(cmd_channel), .busy(busy),
        .cmd_rst_req(cmd_rst_req), .err_sticky(err_sticky), .ram_ext_en(ram_ext_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // drive at negedge, return at the following negedge (state updated)
    task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic with_done);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; done_i = with_done;
        @(negedge clk);
        bus_we = 1'b0; done_i = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_CMD, v); check("R1 cmd word", v, 16'h0000);
        rd(A_DBG, v); check("R1 dbg word", v, 16'h0000);
        check("R1 flags", {12'h0, busy, err_sticky, cmd_rst_req, ram_ext_en}, 16'h0);
    endtask

    task automatic t_issue();
        logic [15:0] v;
        wr(A_CMD, 16'h0A53, 1'b0);
        rd(A_CMD, v); check("R2 word", v, 16'h0A51);
        check("R2 opcode", {12'h0, cmd_opcode}, 16'h000A);
        check("R2 channel", {12'h0, cmd_channel}, 16'h0005);
        check("R2 busy", {15'h0, busy}, 16'h1);
    endtask

    task automatic t_done();
        logic [15:0] v;
        done_pulse();
        check("R3 busy clear", {15'h0, busy}, 16'h0);
        rd(A_CMD, v); check("R3 fields kept", v, 16'h0A50);
    endtask

    task automatic t_done_idle();
        logic [15:0] v;
        done_pulse();
        rd(A_CMD, v); check("R8 idle done", v, 16'h0A50);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        wr(A_CMD, 16'h0C20, 1'b0);
        wr(A_CMD, 16'h0690, 1'b1);
        rd(A_CMD, v); check("R6 applied", v, 16'h0691);
        check("R6 no error", {15'h0, err_sticky}, 16'h0);
    endtask

    task automatic t_busy_drop();
        logic [15:0] v;
        wr(A_CMD, 16'h0370, 1'b0);
        rd(A_CMD, v); check("R4 dropped", v, 16'h0691);
        check("R5 error set", {15'h0, err_sticky}, 16'h1);
    endtask

    task automatic t_rst_cmd();
        logic [15:0] v;
        wr(A_CMD, 16'h8001, 1'b0);
        check("R7 pulse high", {15'h0, cmd_rst_req}, 16'h1);
        rd(A_CMD, v); check("R7 word", v, 16'h8001);
        check("R7 opcode cleared", {12'h0, cmd_opcode}, 16'h0);
        @(negedge clk);
        check("R7 pulse one cycle", {15'h0, cmd_rst_req}, 16'h0);
        check("R7 busy held", {15'h0, busy}, 16'h1);
        done_pulse();
        rd(A_CMD, v); check("R7 after done", v, 16'h0000);
        check("R5 error sticky", {15'h0, err_sticky}, 16'h1);
    endtask

    task automatic t_dbg();
        logic [15:0] v;
        wr(A_DBG, 16'h00FF, 1'b0);
        rd(A_DBG, v); check("R9 readback set", v, 16'h0080);
        check("R9 enable set", {15'h0, ram_ext_en}, 16'h1);
        wr(A_DBG, 16'hFF7F, 1'b0);
        rd(A_DBG, v); check("R9 readback clear", v, 16'h0000);
        check("R9 enable clear", {15'h0, ram_ext_en}, 16'h0);
    endtask

    task automatic t_other();
        logic [15:0] v;
        wr(12'h9C2, 16'hFFFF, 1'b0);
        rd(A_CMD, v); check("R10 cmd untouched", v, 16'h0000);
        check("R10 busy untouched", {15'h0, busy}, 16'h0);
        check("R10 enable untouched", {15'h0, ram_ext_en}, 16'h0);
        rd(12'h9C2, v); check("R10 other read", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_issue();
        t_done();
        t_done_idle();
        t_same_cycle();
        t_busy_drop();
        t_rst_cmd();
        t_dbg();
        t_other();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule